// File: doc/BRIEF.md
# Transceiver Reset Sequencing Controller

This block brings a serial transceiver's phase-locked loops and its transmit and receive datapaths out of reset in a fixed order, and tells each direction's logic when that is finished. Everything it decides runs on one free-running clock that toggles from power-up. Five active-high request inputs may arrive at any time and from any domain. A global request also acts as the controller's own master reset. There is a request that renews a direction's PLL and then its datapath, and a request that renews only a direction's datapath. Each direction has both kinds.

For each direction the sequencer drives the PLL reset for a set number of cycles. It then waits for the lock input and pulses the datapath reset. Next it waits for the primitive's reset-done input, and finally for that direction's user clock to be reported stable. If lock or reset-done does not arrive within a timeout, the sequence starts again at the PLL reset. Each completion flag is carried into its own user-clock domain through a two-flop synchronizer. All request, lock, reset-done and clock-stable inputs pass through two-flop synchronizers into the free-running domain.

A lock or reset-done input must fall while the matching reset is held. The reset pulses are therefore longer than the synchronizer delay. At power-up the global request must be pulsed once.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While the global request is high, both PLL resets are high, both datapath resets are low and both done flags are low. Both full sequences start only after the request falls, and both done flags then rise.
- R2: A full sequence holds the PLL reset for exactly PLL_RST_CYC (default 8) cycles. After lock is seen it holds the datapath reset for exactly DP_RST_CYC (default 8) cycles. It waits for reset-done and clock-stable before done rises, and the datapath reset never rises without lock having been seen first.
- R3: A transmit full request pulses the transmit PLL and datapath resets, and clears and then restores the transmit done flag. The receive resets and the receive done flag stay untouched. The receive full request behaves the same way for the receive direction.
- R4: A datapath-only request pulses only that direction's datapath reset. The PLL reset of that direction stays low.
- R5: Done stays low while that direction's clock-stable input is low. When the input falls after done, done drops with no new reset pulse. Done returns once the input is high again.
- R6: If lock is not seen, the PLL reset rises again after exactly LOCK_TMO (default 64) cycles of waiting.
- R7: If reset-done is not seen, the PLL reset rises exactly RDY_TMO (default 64) cycles after the datapath reset falls.
- R8: A new request clears that direction's done flag and restarts its sequence at once, even in the middle of a wait.
- R9: Each done output changes only on a rising edge of its own user clock, except during a global reset.
- R10: A request pulse one free-running period wide is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fr | input | 1 | Free-running sequencing clock |
| rst_all_req | input | 1 | Global request and master reset, asynchronous |
| tx_full_req | input | 1 | Transmit PLL-plus-datapath request, asynchronous |
| tx_dp_req | input | 1 | Transmit datapath-only request, asynchronous |
| rx_full_req | input | 1 | Receive PLL-plus-datapath request, asynchronous |
| rx_dp_req | input | 1 | Receive datapath-only request, asynchronous |
| tx_uclk_ok | input | 1 | Transmit user clock stable, asynchronous |
| rx_uclk_ok | input | 1 | Receive user clock stable, asynchronous |
| tx_pll_lock | input | 1 | Transmit PLL lock from the primitive |
| rx_pll_lock | input | 1 | Receive PLL lock from the primitive |
| tx_dp_rdy | input | 1 | Transmit datapath reset-done from the primitive |
| rx_dp_rdy | input | 1 | Receive datapath reset-done from the primitive |
| tx_uclk | input | 1 | Transmit user clock |
| rx_uclk | input | 1 | Receive user clock |
| tx_pll_rst | output | 1 | Transmit PLL reset |
| tx_dp_rst | output | 1 | Transmit datapath reset |
| rx_pll_rst | output | 1 | Receive PLL reset |
| rx_dp_rst | output | 1 | Receive datapath reset |
| tx_done | output | 1 | Transmit sequence complete, on tx_uclk |
| rx_done | output | 1 | Receive sequence complete, on rx_uclk |

## Verification
A sequencer stuck in the wrong state shows up at the reset pins within one pulse width. Such faults include a wrong count, a lost timeout or a restart into the wrong step. The PLL or datapath reset then has the wrong width, appears when it should not, or never returns, and all of these are measured cycle by cycle. A fault in the clock-stable gating or in request decoding shows as a done flag that stays high, never falls, or falls in the untouched direction. This is visible a few user-clock edges after the stimulus. A done flag driven from the wrong clock is caught at its first transition.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  localparam int unsigned N_DIR  = 2;
  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;

  typedef enum logic [2:0] {
    SQ_PLL_RST,
    SQ_LOCK_WAIT,
    SQ_DP_RST,
    SQ_RDY_WAIT,
    SQ_UCLK_WAIT,
    SQ_DONE
  } seq_st_e;

  // per-direction synchronized input bundle, one bit each
  localparam int unsigned IN_FULL = 0;
  localparam int unsigned IN_DP   = 1;
  localparam int unsigned IN_OK   = 2;
  localparam int unsigned IN_LOCK = 3;
  localparam int unsigned IN_RDY  = 4;
  localparam int unsigned IN_W    = 5;
endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= {W{RST_VAL}};
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/xrs_dir_seq.sv
module xrs_dir_seq
  import xrs_pkg::*;
#(
  parameter int unsigned PLL_RST_CYC = 8,
  parameter int unsigned DP_RST_CYC  = 8,
  parameter int unsigned LOCK_TMO    = 64,
  parameter int unsigned RDY_TMO     = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start_full,
  input  logic start_dp,
  input  logic lock,
  input  logic rdy,
  input  logic uclk_ok,
  output logic pll_rst,
  output logic dp_rst,
  output logic done
);
  localparam int unsigned MAX_A = (PLL_RST_CYC > DP_RST_CYC) ? PLL_RST_CYC : DP_RST_CYC;
  localparam int unsigned MAX_B = (LOCK_TMO > RDY_TMO) ? LOCK_TMO : RDY_TMO;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW    = $clog2(MAX_C + 1);

  localparam logic [CW-1:0] PLL_LAST  = CW'(PLL_RST_CYC - 1);
  localparam logic [CW-1:0] DP_LAST   = CW'(DP_RST_CYC - 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_TMO - 1);
  localparam logic [CW-1:0] RDY_LAST  = CW'(RDY_TMO - 1);

  seq_st_e       st, st_nx;
  logic [CW-1:0] cnt;
  logic          restart;
  logic          timed;

  always_comb begin
    st_nx = st;
    unique case (st)
      SQ_PLL_RST:   if (cnt == PLL_LAST) st_nx = SQ_LOCK_WAIT;
      SQ_LOCK_WAIT: if (lock) st_nx = SQ_DP_RST;
                    else if (cnt == LOCK_LAST) st_nx = SQ_PLL_RST;
      SQ_DP_RST:    if (cnt == DP_LAST) st_nx = SQ_RDY_WAIT;
      SQ_RDY_WAIT:  if (rdy) st_nx = SQ_UCLK_WAIT;
                    else if (cnt == RDY_LAST) st_nx = SQ_PLL_RST;
      SQ_UCLK_WAIT: if (uclk_ok) st_nx = SQ_DONE;
      SQ_DONE:      if (!uclk_ok) st_nx = SQ_UCLK_WAIT;
      default:      st_nx = SQ_PLL_RST;
    endcase
    // a fresh request overrides whatever the sequence was doing
    if (start_full)    st_nx = SQ_PLL_RST;
    else if (start_dp) st_nx = SQ_DP_RST;
  end

  assign restart = start_full || start_dp || (st_nx != st);
  assign timed   = (st != SQ_UCLK_WAIT) && (st != SQ_DONE);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st      <= SQ_PLL_RST;
      cnt     <= '0;
      pll_rst <= 1'b1;
      dp_rst  <= 1'b0;
      done    <= 1'b0;
    end else begin
      st      <= st_nx;
      if (restart)    cnt <= '0;
      else if (timed) cnt <= cnt + 1'b1;
      pll_rst <= (st_nx == SQ_PLL_RST);
      dp_rst  <= (st_nx == SQ_DP_RST);
      done    <= (st_nx == SQ_DONE);
    end
  end
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
  import xrs_pkg::*;
#(
  parameter int unsigned PLL_RST_CYC = 8,
  parameter int unsigned DP_RST_CYC  = 8,
  parameter int unsigned LOCK_TMO    = 64,
  parameter int unsigned RDY_TMO     = 64,
  parameter int unsigned SYNC_LEN    = 2
) (
  input  logic clk_fr,
  input  logic rst_all_req,
  input  logic tx_full_req,
  input  logic tx_dp_req,
  input  logic rx_full_req,
  input  logic rx_dp_req,
  input  logic tx_uclk_ok,
  input  logic rx_uclk_ok,
  input  logic tx_pll_lock,
  input  logic rx_pll_lock,
  input  logic tx_dp_rdy,
  input  logic rx_dp_rdy,
  input  logic tx_uclk,
  input  logic rx_uclk,
  output logic tx_pll_rst,
  output logic tx_dp_rst,
  output logic rx_pll_rst,
  output logic rx_dp_rst,
  output logic tx_done,
  output logic rx_done
);
  localparam int unsigned SYNC_W = N_DIR * IN_W;

  logic              rst_fr;
  logic [SYNC_W-1:0] raw_in, syn_in;
  logic [N_DIR-1:0]  full_s, dp_s, ok_s, lock_s, rdy_s;
  logic [N_DIR-1:0]  full_q, dp_q;
  logic [N_DIR-1:0]  start_full, start_dp;
  logic [N_DIR-1:0]  pll_rst, dp_rst, done_fr, done_u;
  logic [N_DIR-1:0]  uclk_v;

  // master reset: asserts at once with the global request, releases
  // SYNC_LEN edges after the request falls
  xrs_sync #(.W(1), .STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_rst_bridge (
    .clk (clk_fr),
    .arst(rst_all_req),
    .d   (1'b0),
    .q   (rst_fr)
  );

  assign raw_in[DIR_TX*IN_W +: IN_W] = {tx_dp_rdy, tx_pll_lock, tx_uclk_ok, tx_dp_req, tx_full_req};
  assign raw_in[DIR_RX*IN_W +: IN_W] = {rx_dp_rdy, rx_pll_lock, rx_uclk_ok, rx_dp_req, rx_full_req};
  assign uclk_v = {rx_uclk, tx_uclk};

  xrs_sync #(.W(SYNC_W), .STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_in_sync (
    .clk (clk_fr),
    .arst(rst_fr),
    .d   (raw_in),
    .q   (syn_in)
  );

  always_ff @(posedge clk_fr or posedge rst_fr) begin
    if (rst_fr) begin
      full_q <= '0;
      dp_q   <= '0;
    end else begin
      full_q <= full_s;
      dp_q   <= dp_s;
    end
  end

  for (genvar g = 0; g < N_DIR; g++) begin : g_dir
    assign full_s[g] = syn_in[g*IN_W + IN_FULL];
    assign dp_s[g]   = syn_in[g*IN_W + IN_DP];
    assign ok_s[g]   = syn_in[g*IN_W + IN_OK];
    assign lock_s[g] = syn_in[g*IN_W + IN_LOCK];
    assign rdy_s[g]  = syn_in[g*IN_W + IN_RDY];

    assign start_full[g] = full_s[g] & ~full_q[g];
    assign start_dp[g]   = dp_s[g] & ~dp_q[g];

    xrs_dir_seq #(
      .PLL_RST_CYC(PLL_RST_CYC),
      .DP_RST_CYC (DP_RST_CYC),
      .LOCK_TMO   (LOCK_TMO),
      .RDY_TMO    (RDY_TMO)
    ) u_seq (
      .clk       (clk_fr),
      .rst       (rst_fr),
      .start_full(start_full[g]),
      .start_dp  (start_dp[g]),
      .lock      (lock_s[g]),
      .rdy       (rdy_s[g]),
      .uclk_ok   (ok_s[g]),
      .pll_rst   (pll_rst[g]),
      .dp_rst    (dp_rst[g]),
      .done      (done_fr[g])
    );

    xrs_sync #(.W(1), .STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_done_sync (
      .clk (uclk_v[g]),
      .arst(rst_fr),
      .d   (done_fr[g]),
      .q   (done_u[g])
    );
  end

  assign tx_pll_rst = pll_rst[DIR_TX];
  assign tx_dp_rst  = dp_rst[DIR_TX];
  assign rx_pll_rst = pll_rst[DIR_RX];
  assign rx_dp_rst  = dp_rst[DIR_RX];
  assign tx_done    = done_u[DIR_TX];
  assign rx_done    = done_u[DIR_RX];
endmodule

// File: rtl/xrs_chk.sv
module xrs_chk
  import xrs_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [N_DIR-1:0] start_full,
  input logic [N_DIR-1:0] start_dp,
  input logic [N_DIR-1:0] lock_s,
  input logic [N_DIR-1:0] ok_s,
  input logic [N_DIR-1:0] pll_rst,
  input logic [N_DIR-1:0] dp_rst,
  input logic [N_DIR-1:0] done_fr
);
  for (genvar g = 0; g < N_DIR; g++) begin : g_chk
    assert_restart_clears_done_R8: assert property (@(posedge clk) disable iff (rst)
      (start_full[g] || start_dp[g]) |=> !done_fr[g]);

    assert_done_needs_uclk_R5: assert property (@(posedge clk) disable iff (rst)
      !ok_s[g] |=> !done_fr[g]);

    assert_dp_after_lock_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(dp_rst[g]) |-> ($past(lock_s[g]) || $past(start_dp[g])));

    assert_dp_only_spares_pll_R4: assert property (@(posedge clk) disable iff (rst)
      (start_dp[g] && !start_full[g]) |=> !pll_rst[g]);

    assert_pll_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(pll_rst[g]) |=> (pll_rst[g] || $past(start_dp[g])));
  end
endmodule

bind xcvr_rst_seq xrs_chk u_xrs_chk (
  .clk       (clk_fr),
  .rst       (rst_fr),
  .start_full(start_full),
  .start_dp  (start_dp),
  .lock_s    (lock_s),
  .ok_s      (ok_s),
  .pll_rst   (pll_rst),
  .dp_rst    (dp_rst),
  .done_fr   (done_fr)
);

// File: tb/xcvr_rst_seq_tb_top.sv
`timescale 1ns/1ps
module xcvr_rst_seq_tb_top;
  localparam int PLL_RST_CYC = 8;
  localparam int DP_RST_CYC  = 8;
  localparam int LOCK_TMO    = 64;
  localparam int RDY_TMO     = 64;
  localparam int MODEL_DLY   = 5;

  // {request code[8:6], expected seen tx_pll,tx_dp,rx_pll,rx_dp [5:2], expected done drop tx,rx [1:0]}
  // request codes: 0 global, 1 tx full, 2 tx datapath, 3 rx full, 4 rx datapath
  localparam logic [8:0] VEC [6] = '{
    {3'd1, 4'b1100, 2'b10},
    {3'd2, 4'b0100, 2'b10},
    {3'd3, 4'b0011, 2'b01},
    {3'd4, 4'b0001, 2'b01},
    {3'd0, 4'b1111, 2'b11},
    {3'd1, 4'b1100, 2'b10}
  };

  logic clk = 1'b0, tx_uclk = 1'b0, rx_uclk = 1'b0;
  always #2.5 clk = ~clk;
  always #4.0 tx_uclk = ~tx_uclk;
  always #3.0 rx_uclk = ~rx_uclk;

  logic glob_req = 1'b1;
  logic [4:1] req = '0;
  logic [1:0] uok = 2'b11;
  logic [1:0] lock = 2'b00, rdy = 2'b00;
  logic [1:0] blk_lock = 2'b00, blk_rdy = 2'b00;
  int   lk_cnt [2] = '{0, 0};
  int   rd_cnt [2] = '{0, 0};
  logic tx_pll_rst, tx_dp_rst, rx_pll_rst, rx_dp_rst, tx_done, rx_done;

  xcvr_rst_seq dut_i (
    .clk_fr(clk), .rst_all_req(glob_req),
    .tx_full_req(req[1]), .tx_dp_req(req[2]), .rx_full_req(req[3]), .rx_dp_req(req[4]),
    .tx_uclk_ok(uok[0]), .rx_uclk_ok(uok[1]),
    .tx_pll_lock(lock[0]), .rx_pll_lock(lock[1]),
    .tx_dp_rdy(rdy[0]), .rx_dp_rdy(rdy[1]),
    .tx_uclk(tx_uclk), .rx_uclk(rx_uclk),
    .tx_pll_rst(tx_pll_rst), .tx_dp_rst(tx_dp_rst),
    .rx_pll_rst(rx_pll_rst), .rx_dp_rst(rx_dp_rst),
    .tx_done(tx_done), .rx_done(rx_done)
  );

  // primitive model: lock and reset-done drop while the matching reset is high
  wire [1:0] pll_o = {rx_pll_rst, tx_pll_rst};
  wire [1:0] dp_o  = {rx_dp_rst, tx_dp_rst};
  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (pll_o[d]) begin lock[d] <= 1'b0; lk_cnt[d] <= 0; end
      else if (!lock[d] && !blk_lock[d]) begin
        if (lk_cnt[d] == MODEL_DLY) lock[d] <= 1'b1; else lk_cnt[d] <= lk_cnt[d] + 1;
      end
      if (dp_o[d] || pll_o[d]) begin rdy[d] <= 1'b0; rd_cnt[d] <= 0; end
      else if (!rdy[d] && !blk_rdy[d]) begin
        if (rd_cnt[d] == MODEL_DLY) rdy[d] <= 1'b1; else rd_cnt[d] <= rd_cnt[d] + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
  bit finished = 1'b0;

  // R9 monitor: done outputs move only on their own user-clock edge
  int  gw_cnt = 30;
  wire glob_win = glob_req || (gw_cnt != 0);
  always @(posedge clk) if (glob_req) gw_cnt <= 30; else if (gw_cnt > 0) gw_cnt <= gw_cnt - 1;
  realtime t_tx = 0.0, t_rx = 0.0;
  always @(posedge tx_uclk) t_tx = $realtime;
  always @(posedge rx_uclk) t_rx = $realtime;
  always @(tx_done) if (!glob_win) begin
    m_chk++;
    if ($realtime != t_tx) begin m_fail++; $display("FAIL R9: tx_done moved at %0t, last tx edge %0t", $realtime, t_tx); end
  end
  always @(rx_done) if (!glob_win) begin
    m_chk++;
    if ($realtime != t_rx) begin m_fail++; $display("FAIL R9: rx_done moved at %0t, last rx edge %0t", $realtime, t_rx); end
  end

  logic mon = 1'b0;
  logic [3:0] seen;
  logic [1:0] drop;
  always @(negedge clk) if (mon) begin
    seen <= seen | {tx_pll_rst, tx_dp_rst, rx_pll_rst, rx_dp_rst};
    drop <= drop | {~tx_done, ~rx_done};
  end

  function automatic logic sig(input int k);
    case (k)
      0: return tx_pll_rst;
      1: return tx_dp_rst;
      2: return rx_pll_rst;
      3: return rx_dp_rst;
      4: return tx_done;
      default: return rx_done;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s: actual %0d expected %0d", rq, act, exp); end
  endtask

  task automatic wait_for(input int k, input logic v, input int lim, output int n);
    n = 0;
    while (sig(k) !== v && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic pulse(input int code);
    @(negedge clk);
    if (code == 0) glob_req = 1'b1; else req[code] = 1'b1;
    @(negedge clk);
    if (code == 0) glob_req = 1'b0; else req[code] = 1'b0;
  endtask

  task automatic wait_both_done(input string rq);
    int n;
    wait_for(4, 1'b1, 3000, n); chk(tx_done === 1'b1, rq, tx_done, 1);
    wait_for(5, 1'b1, 3000, n); chk(rx_done === 1'b1, rq, rx_done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk + 1, n_fail + m_fail + 1);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: state while the global request is held
    repeat (10) @(negedge clk);
    chk(tx_pll_rst === 1'b1 && rx_pll_rst === 1'b1, "R1 pll resets in global", {tx_pll_rst, rx_pll_rst}, 3);
    chk(tx_dp_rst === 1'b0 && rx_dp_rst === 1'b0, "R1 dp resets in global", {tx_dp_rst, rx_dp_rst}, 0);
    chk(tx_done === 1'b0 && rx_done === 1'b0, "R1 done in global", {tx_done, rx_done}, 0);
    glob_req = 1'b0;
    wait_both_done("R1 bring-up after fall");

    // R2: exact pulse widths of a full transmit sequence
    pulse(1);
    wait_for(0, 1'b1, 20, n);
    wait_for(0, 1'b0, 100, n); chk(n == PLL_RST_CYC, "R2 pll reset width", n, PLL_RST_CYC);
    wait_for(1, 1'b1, 50, n);
    wait_for(1, 1'b0, 100, n); chk(n == DP_RST_CYC, "R2 dp reset width", n, DP_RST_CYC);
    wait_both_done("R2 completion");

    // table walk: R3, R4, R8 (done clears), R10 (one-period requests)
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); seen = '0; drop = '0; mon = 1'b1;
      pulse(int'(VEC[i][8:6]));
      repeat (30) @(negedge clk);
      wait_both_done("R3 R4 table completion");
      repeat (2) @(negedge clk);
      mon = 1'b0;
      chk(seen == VEC[i][5:2], "R3 R4 R10 resets seen", seen, VEC[i][5:2]);
      chk(drop == VEC[i][1:0], "R8 R3 done drops", drop, VEC[i][1:0]);
    end

    // R6: lock timeout restarts the PLL reset
    blk_lock[0] = 1'b1;
    pulse(1);
    wait_for(0, 1'b1, 20, n);
    wait_for(0, 1'b0, 100, n);
    wait_for(0, 1'b1, 500, n); chk(n == LOCK_TMO, "R6 lock wait length", n, LOCK_TMO);
    blk_lock[0] = 1'b0;
    wait_both_done("R6 recovery");

    // R7: reset-done timeout restarts at the PLL reset
    blk_rdy[0] = 1'b1;
    pulse(2);
    wait_for(1, 1'b1, 20, n);
    wait_for(1, 1'b0, 100, n);
    wait_for(0, 1'b1, 500, n); chk(n == RDY_TMO, "R7 reset-done wait length", n, RDY_TMO);
    blk_rdy[0] = 1'b0;
    wait_both_done("R7 recovery");

    // R8: request in the middle of the lock wait restarts at once
    blk_lock[0] = 1'b1;
    pulse(1);
    wait_for(0, 1'b1, 20, n);
    wait_for(0, 1'b0, 100, n);
    repeat (5) @(negedge clk);
    pulse(1);
    wait_for(0, 1'b1, 40, n); chk(n < 10, "R8 mid-wait restart delay", n, 9);
    blk_lock[0] = 1'b0;
    wait_both_done("R8 recovery");

    // R5: clock-stable loss after done drops done without a new pulse
    @(negedge clk); seen = '0; mon = 1'b1;
    uok[1] = 1'b0;
    repeat (20) @(negedge clk);
    chk(rx_done === 1'b0, "R5 rx done follows clock-stable", rx_done, 0);
    uok[1] = 1'b1;
    wait_for(5, 1'b1, 30, n); chk(rx_done === 1'b1, "R5 rx done returns", rx_done, 1);
    mon = 1'b0;
    chk(seen[1:0] == 2'b00, "R5 no rx reset pulse", seen[1:0], 0);

    // R5: sequence gated by clock-stable low
    uok[0] = 1'b0;
    pulse(2);
    repeat (200) @(negedge clk);
    chk(tx_done === 1'b0, "R5 tx done held while clock unstable", tx_done, 0);
    uok[0] = 1'b1;
    wait_for(4, 1'b1, 30, n); chk(tx_done === 1'b1, "R5 tx done after clock stable", tx_done, 1);

    chk(m_chk > 0, "R9 done transitions observed", m_chk, 1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_fail + m_fail);
    $finish;
  end
endmodule